// File: doc/BRIEF.md
# Receive Word Aligner with Training-Pattern Lock

This block sits between a receive deserialiser and an 8b/10b decoder. Each word-clock cycle it takes one 20-bit raw word, which carries two 10-bit line symbols. It joins that word with the word from the cycle before, and a barrel shifter picks out a 20-bit window from the joined pair. The bit offset of the window decides where the recovered word boundary falls. The aligned word goes to the decoder, and the block also compares it against a fixed training pattern.

An outer calibration loop can load the offset directly or nudge it up by one with a strobe. In autonomous mode the block searches by itself: it moves to the next offset after a fixed run of words without a pattern match, and it stops searching once it has lock. Lock is a filtered view of the match flag. It is set only after a run of consecutive matches and cleared only after a run of consecutive misses, so a single corrupted word does not disturb a calibration loop that is waiting for it.

Top module: `rx_word_aligner`

## Requirements
- R1: During and just after reset, `offset` is 0, `aligned_word` is 0, and `pat_det` and `locked` are low.
- R2: Let the joined vector be J = {current raw word, previous raw word}, where bit 0 is the previous word's bit 0 and bit 20 is the current word's bit 0. One clock after a raw word is presented, `aligned_word[i]` equals J[offset + i], using the offset held during that cycle.
- R3: `pat_det` is registered in the same cycle as `aligned_word`. It is high exactly when that aligned word equals the training pattern (default 20'h3EB05).
- R4: When `off_ld` is high and `off_val` is at most 19, `offset` takes `off_val` at the next clock. A load with `off_val` above 19 is ignored: the offset and the lock state stay as they were.
- R5: A `step_req` pulse without a valid load moves the offset up by one, and 19 wraps to 0. A valid load takes priority over a step in the same cycle.
- R6: `locked` rises at the clock that registers the 4th consecutive matching window at an unchanged offset, and not before.
- R7: Once locked, `locked` stays high through up to 3 consecutive misses, and a match resets the miss run. It falls at the clock that registers the 4th consecutive miss.
- R8: With `auto_en` high and `locked` low, each run of 8 consecutive non-matching windows advances the offset by one, with 19 wrapping to 0. No autonomous stepping happens while `locked` is high or while `auto_en` is low.
- R9: Any change of the offset value clears `locked` and restarts the match, miss and search runs, and the window registered at that same clock is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_word | input | 20 | Raw word from the deserialiser, one per cycle |
| auto_en | input | 1 | Enables the autonomous offset search |
| step_req | input | 1 | Strobe that advances the offset by one |
| off_ld | input | 1 | Loads `off_val` into the offset |
| off_val | input | 5 | Offset value to load (0 to 19) |
| aligned_word | output | 20 | Window selected by the barrel shifter, registered |
| pat_det | output | 1 | Aligned word equals the training pattern |
| offset | output | 5 | Offset currently in use |
| locked | output | 1 | Filtered alignment lock |

## Verification
The hardest state to reach is a search in autonomous mode that runs through the top offset, wraps to zero and then locks at a lower offset. Getting there takes more than 150 cycles in which no window may match by accident. The bench feeds a constant training word rotated by a known skew that sits below the starting offset. Because every rotation of the pattern is distinct, only the wrapped target offset can match. A second hard point is a locked link that takes three misses and then recovers on the very next word. For this, a zero burst is placed so that the transition windows are also misses, followed by the rotated pattern, so the fourth window matches exactly.

// File: rtl/rx_align_pkg.sv
package rx_align_pkg;

    localparam int          RXA_WORD_W   = 20;
    localparam logic [19:0] RXA_TRAIN    = 20'h3EB05;
    localparam int          RXA_LOCK_N   = 4;
    localparam int          RXA_UNLOCK_N = 4;
    localparam int          RXA_SEARCH_N = 8;

    typedef enum logic [1:0] {
        LK_HUNT    = 2'd0,
        LK_CONFIRM = 2'd1,
        LK_HELD    = 2'd2,
        LK_SLIP    = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic search;
    } off_cause_t;

    function automatic int unsigned wrap_next(int unsigned cur, int unsigned modulus);
        return (cur + 1 >= modulus) ? 0 : cur + 1;
    endfunction

    function automatic bit lock_asserted(lock_state_e st);
        return (st == LK_HELD) || (st == LK_SLIP);
    endfunction

endpackage

// File: rtl/rxa_window_sel.sv
module rxa_window_sel
    import rx_align_pkg::*;
#(
    parameter int WORD_W = RXA_WORD_W,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_in,
    input  logic [OFF_W-1:0]  sel_off,
    output logic [WORD_W-1:0] window,
    output logic [WORD_W-1:0] window_q
);

    localparam int JOIN_W = 2 * WORD_W;

    logic [WORD_W-1:0] prev_q;
    logic [JOIN_W-1:0] joined;
    logic [WORD_W-1:0] cand [WORD_W];

    assign joined = {raw_in, prev_q};

    for (genvar k = 0; k < WORD_W; k++) begin : g_cand
        assign cand[k] = joined[k +: WORD_W];
    end

    always_comb begin
        window = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (sel_off == OFF_W'(k)) begin
                window = cand[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            window_q <= '0;
        end else begin
            prev_q   <= raw_in;
            window_q <= window;
        end
    end

endmodule

// File: rtl/rxa_lock_track.sv
module rxa_lock_track
    import rx_align_pkg::*;
#(
    parameter int LOCK_N   = RXA_LOCK_N,
    parameter int UNLOCK_N = RXA_UNLOCK_N
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic restart,
    output logic hit_q,
    output logic locked
);

    localparam int MAX_N = (LOCK_N > UNLOCK_N) ? LOCK_N : UNLOCK_N;
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam logic [CNT_W-1:0] LOCK_LAST   = CNT_W'(LOCK_N - 1);
    localparam logic [CNT_W-1:0] UNLOCK_LAST = CNT_W'(UNLOCK_N - 1);

    lock_state_e      st_q, st_d;
    logic [CNT_W-1:0] run_q, run_d;

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (restart) begin
            st_d  = LK_HUNT;
            run_d = '0;
        end else begin
            unique case (st_q)
                LK_HUNT: begin
                    if (hit) begin
                        st_d  = LK_CONFIRM;
                        run_d = CNT_W'(1);
                    end
                end
                LK_CONFIRM: begin
                    if (!hit) begin
                        st_d  = LK_HUNT;
                        run_d = '0;
                    end else if (run_q == LOCK_LAST) begin
                        st_d  = LK_HELD;
                        run_d = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                LK_HELD: begin
                    if (!hit) begin
                        st_d  = LK_SLIP;
                        run_d = CNT_W'(1);
                    end
                end
                LK_SLIP: begin
                    if (hit) begin
                        st_d  = LK_HELD;
                        run_d = '0;
                    end else if (run_q == UNLOCK_LAST) begin
                        st_d  = LK_HUNT;
                        run_d = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = LK_HUNT;
                    run_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_HUNT;
            run_q <= '0;
            hit_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
            hit_q <= hit;
        end
    end

    assign locked = lock_asserted(st_q);

endmodule

// File: rtl/rxa_offset_ctrl.sv
module rxa_offset_ctrl
    import rx_align_pkg::*;
#(
    parameter int WORD_W   = RXA_WORD_W,
    parameter int SEARCH_N = RXA_SEARCH_N,
    parameter int OFF_W    = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             step_req,
    input  logic             off_ld,
    input  logic [OFF_W-1:0] off_val,
    input  logic             hit,
    input  logic             locked,
    output logic [OFF_W-1:0] off_q,
    output logic             off_change
);

    localparam int SRCH_W = $clog2(SEARCH_N + 1);
    localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(WORD_W - 1);
    localparam logic [SRCH_W-1:0] SRCH_LAST = SRCH_W'(SEARCH_N - 1);

    off_cause_t        cause;
    logic [OFF_W-1:0]  off_inc, off_d;
    logic [SRCH_W-1:0] srch_q, srch_d;
    logic              searching;

    assign off_inc   = OFF_W'(wrap_next(32'(off_q), 32'(WORD_W)));
    assign searching = auto_en && !locked;

    always_comb begin
        cause.load   = off_ld && (off_val <= LAST_OFF);
        cause.step   = step_req && !cause.load;
        cause.search = searching && !cause.load && !cause.step
                       && !hit && (srch_q == SRCH_LAST);
    end

    always_comb begin
        off_d  = off_q;
        srch_d = srch_q;
        if (cause.load) begin
            off_d = off_val;
        end else if (cause.step || cause.search) begin
            off_d = off_inc;
        end
        if (!searching || hit) begin
            srch_d = '0;
        end else if (srch_q != SRCH_LAST) begin
            srch_d = srch_q + 1'b1;
        end
        if (off_d != off_q) begin
            srch_d = '0;
        end
    end

    assign off_change = (off_d != off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            srch_q <= '0;
        end else begin
            off_q  <= off_d;
            srch_q <= srch_d;
        end
    end

endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
    import rx_align_pkg::*;
#(
    parameter int                WORD_W    = RXA_WORD_W,
    parameter logic [WORD_W-1:0] TRAIN_PAT = WORD_W'(RXA_TRAIN),
    parameter int                LOCK_N    = RXA_LOCK_N,
    parameter int                UNLOCK_N  = RXA_UNLOCK_N,
    parameter int                SEARCH_N  = RXA_SEARCH_N,
    parameter int                OFF_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] raw_word,
    input  logic              auto_en,
    input  logic              step_req,
    input  logic              off_ld,
    input  logic [OFF_W-1:0]  off_val,
    output logic [WORD_W-1:0] aligned_word,
    output logic              pat_det,
    output logic [OFF_W-1:0]  offset,
    output logic              locked
);

    logic [WORD_W-1:0] window;
    logic              hit;
    logic              off_change;

    rxa_window_sel #(
        .WORD_W (WORD_W),
        .OFF_W  (OFF_W)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (raw_word),
        .sel_off  (offset),
        .window   (window),
        .window_q (aligned_word)
    );

    assign hit = (window == TRAIN_PAT);

    rxa_offset_ctrl #(
        .WORD_W   (WORD_W),
        .SEARCH_N (SEARCH_N),
        .OFF_W    (OFF_W)
    ) u_off (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .step_req   (step_req),
        .off_ld     (off_ld),
        .off_val    (off_val),
        .hit        (hit),
        .locked     (locked),
        .off_q      (offset),
        .off_change (off_change)
    );

    rxa_lock_track #(
        .LOCK_N   (LOCK_N),
        .UNLOCK_N (UNLOCK_N)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .restart (off_change),
        .hit_q   (pat_det),
        .locked  (locked)
    );

endmodule

// File: rtl/rx_word_aligner_chk.sv
module rx_word_aligner_chk #(
    parameter int                WORD_W    = 20,
    parameter logic [WORD_W-1:0] TRAIN_PAT = '0,
    parameter int                OFF_W     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              auto_en,
    input logic              step_req,
    input logic              off_ld,
    input logic [OFF_W-1:0]  off_val,
    input logic [WORD_W-1:0] aligned_word,
    input logic              pat_det,
    input logic [OFF_W-1:0]  offset,
    input logic              locked
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_W - 1);

    a_r3_det_means_pattern: assert property (@(posedge clk) disable iff (rst)
        pat_det |-> (aligned_word == TRAIN_PAT));

    a_r4_load_takes_value: assert property (@(posedge clk) disable iff (rst)
        (off_ld && off_val <= LAST_OFF) |=> (offset == $past(off_val)));

    a_r5_step_wraps: assert property (@(posedge clk) disable iff (rst)
        (step_req && !off_ld) |=>
            (offset == (($past(offset) == LAST_OFF) ? '0 : $past(offset) + 1'b1)));

    a_r6_lock_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (pat_det && $past(pat_det) && $past(pat_det, 2) && $past(pat_det, 3)));

    a_r7_unlock_needs_run: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && $stable(offset)) |->
            (!pat_det && !$past(pat_det) && !$past(pat_det, 2) && !$past(pat_det, 3)));

    a_r8_manual_holds: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !step_req && !off_ld) |=> $stable(offset));

    a_r8_locked_holds: assert property (@(posedge clk) disable iff (rst)
        (locked && !step_req && !off_ld) |=> $stable(offset));

    a_r9_change_unlocks: assert property (@(posedge clk) disable iff (rst)
        !$stable(offset) |-> !locked);

endmodule

bind rx_word_aligner rx_word_aligner_chk #(
    .WORD_W    (WORD_W),
    .TRAIN_PAT (TRAIN_PAT),
    .OFF_W     (OFF_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .auto_en      (auto_en),
    .step_req     (step_req),
    .off_ld       (off_ld),
    .off_val      (off_val),
    .aligned_word (aligned_word),
    .pat_det      (pat_det),
    .offset       (offset),
    .locked       (locked)
);

// File: tb/rx_word_aligner_tb.sv
`timescale 1ns/100ps
module rx_word_aligner_tb;

    localparam logic [19:0] PAT = 20'h3EB05;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] raw_word = '0;
    logic        auto_en = 1'b0;
    logic        step_req = 1'b0;
    logic        off_ld = 1'b0;
    logic [4:0]  off_val = '0;
    logic [19:0] aligned_word;
    logic        pat_det;
    logic [4:0]  offset;
    logic        locked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rx_word_aligner u_dut (
        .clk          (clk),
        .rst          (rst),
        .raw_word     (raw_word),
        .auto_en      (auto_en),
        .step_req     (step_req),
        .off_ld       (off_ld),
        .off_val      (off_val),
        .aligned_word (aligned_word),
        .pat_det      (pat_det),
        .offset       (offset),
        .locked       (locked)
    );

    function automatic logic [19:0] rotl(logic [19:0] x, int s);
        logic [19:0] r;
        for (int i = 0; i < 20; i++) r[(i + s) % 20] = x[i];
        return r;
    endfunction

    function automatic logic [19:0] exp_win(logic [19:0] prv, logic [19:0] cur, int k);
        logic [19:0] w;
        for (int i = 0; i < 20; i++) w[i] = (i + k < 20) ? prv[i + k] : cur[i + k - 20];
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_req = 1'b0;
        off_ld = 1'b0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        raw_word = PAT;
        do_reset();
        check("R1 offset", 32'(offset), 0);
        check("R1 aligned", 32'(aligned_word), 0);
        check("R1 pat_det", 32'(pat_det), 0);
        check("R1 locked", 32'(locked), 0);
    endtask

    task automatic t_window();
        logic [19:0] a = 20'hA5C3E, b = 20'h1F0D7, c = 20'h6B2E9, d = 20'h93471;
        auto_en = 1'b0;
        do_reset();
        raw_word = a; off_ld = 1'b1; off_val = 5'd7;
        tick();
        off_ld = 1'b0; raw_word = b;
        tick();
        check("R2 offset 7", 32'(aligned_word), 32'(exp_win(a, b, 7)));
        check("R3 no detect", 32'(pat_det), 32'(exp_win(a, b, 7) == PAT));
        raw_word = c; off_ld = 1'b1; off_val = 5'd0;
        tick();
        off_ld = 1'b0; raw_word = d;
        tick();
        check("R2 offset 0", 32'(aligned_word), 32'(c));
        raw_word = a; off_ld = 1'b1; off_val = 5'd19;
        tick();
        off_ld = 1'b0; raw_word = b;
        tick();
        check("R2 offset 19", 32'(aligned_word), 32'(exp_win(a, b, 19)));
    endtask

    task automatic t_manual_offset();
        auto_en = 1'b0;
        do_reset();
        off_ld = 1'b1; off_val = 5'd19;
        tick();
        off_ld = 1'b0;
        check("R4 load 19", 32'(offset), 19);
        step_req = 1'b1;
        tick();
        step_req = 1'b0;
        check("R5 wrap 19 to 0", 32'(offset), 0);
        off_ld = 1'b1; off_val = 5'd4; step_req = 1'b1;
        tick();
        off_ld = 1'b0; step_req = 1'b0;
        check("R5 load beats step", 32'(offset), 4);
        off_ld = 1'b1; off_val = 5'd25;
        tick();
        off_ld = 1'b0;
        check("R4 load 25 ignored", 32'(offset), 4);
        raw_word = 20'h12345;
        tick(12);
        check("R8 no search when manual", 32'(offset), 4);
    endtask

    task automatic t_lock_cycle();
        logic [19:0] w = rotl(PAT, 9);
        auto_en = 1'b0;
        raw_word = w;
        do_reset();
        tick();
        off_ld = 1'b1; off_val = 5'd9;
        tick();
        off_ld = 1'b0;
        tick(3);
        check("R3 detect at skew", 32'(pat_det), 1);
        check("R6 not locked after 3", 32'(locked), 0);
        tick();
        check("R6 locked after 4", 32'(locked), 1);
        raw_word = '0;
        tick(2);
        raw_word = w;
        tick();
        check("R7 held after 3 misses", 32'(locked), 1);
        check("R3 miss flagged", 32'(pat_det), 0);
        tick();
        check("R7 recovered", 32'(locked), 1);
        raw_word = '0;
        tick(3);
        check("R7 held after 3 more", 32'(locked), 1);
        tick();
        check("R7 dropped after 4", 32'(locked), 0);
        check("R8 offset kept", 32'(offset), 9);
        raw_word = w;
        tick(5);
        check("R6 relocked", 32'(locked), 1);
        off_ld = 1'b1; off_val = 5'd30;
        tick();
        off_ld = 1'b0;
        check("R4 bad load keeps lock", 32'(locked), 1);
        check("R4 bad load keeps offset", 32'(offset), 9);
        step_req = 1'b1;
        tick();
        step_req = 1'b0;
        check("R9 step clears lock", 32'(locked), 0);
        check("R5 step while locked", 32'(offset), 10);
        off_ld = 1'b1; off_val = 5'd9;
        tick();
        off_ld = 1'b0;
        tick(3);
        check("R9 run restarted", 32'(locked), 0);
        tick();
        check("R9 lock after fresh run", 32'(locked), 1);
    endtask

    task automatic t_auto_search();
        raw_word = rotl(PAT, 5);
        auto_en = 1'b1;
        do_reset();
        tick(7);
        check("R8 before first step", 32'(offset), 0);
        tick();
        check("R8 step after 8 misses", 32'(offset), 1);
        tick(31);
        check("R8 offset 4 at 39", 32'(offset), 4);
        tick();
        check("R8 offset 5 at 40", 32'(offset), 5);
        tick(3);
        check("R6 auto not yet locked", 32'(locked), 0);
        tick();
        check("R6 auto locked", 32'(locked), 1);
        tick(20);
        check("R8 no search when locked", 32'(offset), 5);
        auto_en = 1'b0;
    endtask

    task automatic t_auto_wrap();
        raw_word = rotl(PAT, 2);
        auto_en = 1'b0;
        do_reset();
        tick();
        off_ld = 1'b1; off_val = 5'd3;
        tick();
        off_ld = 1'b0; auto_en = 1'b1;
        tick(8 * 16);
        check("R8 reached 19", 32'(offset), 19);
        tick(8);
        check("R8 wrap 19 to 0", 32'(offset), 0);
        tick(15);
        check("R8 offset 1", 32'(offset), 1);
        tick();
        check("R8 offset 2", 32'(offset), 2);
        tick(4);
        check("R6 lock after wrap", 32'(locked), 1);
        check("R2 aligned is pattern", 32'(aligned_word), 32'(PAT));
        auto_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_window();
        t_manual_offset();
        t_lock_cycle();
        t_auto_search();
        t_auto_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule